// File: doc/BRIEF.md
# Line-Mapped Monochrome Pixel Scanout with Hardware Cursor

This block turns a one-bit-per-pixel frame buffer into a serial pixel stream for a 1024-column by 864-row display. Rows are not addressed linearly: every displayed row first reads its own entry in a row map held in the same memory. That entry names the stored buffer row whose 32 words are then streamed out. Software can therefore scroll or duplicate rows just by rewriting map entries.

A 16 by 16 cursor image, also kept in memory, is overlaid on the stream. Its vertical position is computed from character-cell style settings: the cell row index times the cell height (maximum scan row plus one), plus a scan-row offset. The top bit of the offset hides the cursor. The overlay either ORs the cursor into the memory pixel or clears the memory pixel where the cursor bit is set. A video-on control gates the whole output.

An external timing source drives the block. It gives a `line_go` pulse with the row number during horizontal blanking, then one `pix_en` strobe per visible column with its column number. Memory is a single read port with one cycle of latency: data for a request made in cycle t is presented in cycle t+1. A state machine controls the fetches. On `line_go`, from any state, it moves to FETCH_MAP (ST_MAP_REQ), then CURSOR (ST_CUR_REQ), WORD0 (ST_W0_REQ), WORD1 (ST_W1_REQ) and FILL (ST_W1_WAIT), and then enters SCAN (ST_SCAN). In SCAN it refills its one-word-ahead buffer at each word boundary. It returns to IDLE (ST_IDLE) after column 1023 is consumed.

Top module: `mono_scanout`

## Requirements
- R1: While reset is held and in the cycle after it is released, `pix_vld`, `pix_out` and `mem_req` are 0.
- R2: For row y the map word is read at word address MAP_BASE + y/2 (default 0xFE00). Bits [10:0] hold the buffer row for an even y and bits [26:16] for an odd y. All other bits of the map word are ignored.
- R3: Column c of a row whose buffer row is b comes from the word at address b*32 + c/32, bit c mod 32 (least significant bit is the leftmost pixel).
- R4: The first `pix_en` of a row may come 5 cycles after the `line_go` cycle. Each `pix_en` produces `pix_vld`=1 with its pixel exactly one cycle later. Without `pix_en`, `pix_vld` and `pix_out` are 0.
- R5: Cursor top row = `cur_addr_hi` * (`max_scan` + 1) + `scan_start`[4:0]. The cursor is shown only when `scan_start`[5] is 0.
- R6: The cursor covers columns `cursor_x` .. `cursor_x`+15 (10-bit `cursor_x`). Parts beyond column 1023 are clipped and never wrap to column 0.
- R7: Cursor image row r is read from word CUR_BASE + r/2 (default 0xFFF8): bits [15:0] for an even r, bits [31:16] for an odd r. Bit k covers column `cursor_x`+k.
- R8: When `cur_or` is 1, the output is the memory pixel OR the cursor pixel. When it is 0, the output is the memory pixel AND NOT the cursor pixel.
- R9: When `video_on` is 0, every valid pixel is 0.
- R10: During SCAN a memory read is issued only on the `pix_en` of the last column of a word (column mod 32 = 31). At most 30 such reads are made per row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_go | input | 1 | Start-of-row fetch pulse, given in horizontal blanking |
| line_y | input | 10 | Display row to prepare, sampled with `line_go` |
| pix_en | input | 1 | One visible pixel is requested this cycle |
| pix_col | input | 10 | Column of the requested pixel, 0..1023 in order |
| cur_or | input | 1 | Cursor combine function: 1 = OR, 0 = AND-NOT |
| video_on | input | 1 | Video output enable |
| cursor_x | input | 10 | Cursor left column |
| cur_addr_hi | input | 8 | Cursor cell row index |
| max_scan | input | 5 | Last scan row of a cell (cell height minus one) |
| scan_start | input | 6 | Cursor scan-row offset; bit 5 hides the cursor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Word address of the read |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| pix_vld | output | 1 | `pix_out` carries a pixel |
| pix_out | output | 1 | Pixel value |

## Verification
Each pixel is due one clock after the edge that accepts its `pix_en`. The bench drives a column on a falling edge and compares `pix_vld`/`pix_out` on the next falling edge, so the rising edge in between is the only one that can have produced the value. Row setup takes five clocks from the edge that accepts `line_go`. The bench waits seven falling edges before the first column, so map, cursor and first two words have arrived. The memory model answers on the rising edge after a request, which matches the one-cycle latency that the SCAN refill depends on. Each expected pixel is computed from the map, data and cursor formulas of the requirements.

// File: rtl/mono_scan_pkg.sv
package mono_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAP_REQ,
        ST_CUR_REQ,
        ST_W0_REQ,
        ST_W1_REQ,
        ST_W1_WAIT,
        ST_SCAN
    } scan_state_e;

endpackage

// File: rtl/mono_cursor_geom.sv
// Derives the cursor top row and decides whether the current row crosses
// the cursor, and which image row it uses.
module mono_cursor_geom #(
    parameter int ROW_W    = 10,
    parameter int AH_W     = 8,
    parameter int MS_W     = 5,
    parameter int SS_W     = 6,
    parameter int CUR_SIZE = 16
) (
    input  logic [ROW_W-1:0]            row,
    input  logic [AH_W-1:0]             cur_addr_hi,
    input  logic [MS_W-1:0]             max_scan,
    input  logic [SS_W-1:0]             scan_start,
    output logic                        row_hit,
    output logic [$clog2(CUR_SIZE)-1:0] row_idx
);
    localparam int CY_W = ((AH_W + MS_W + 2) > (ROW_W + 1)) ? (AH_W + MS_W + 2) : (ROW_W + 1);
    localparam int RI_W = $clog2(CUR_SIZE);

    logic [CY_W-1:0] cell_h;
    logic [CY_W-1:0] top_row;
    logic [CY_W-1:0] row_ext;
    logic [CY_W-1:0] delta;
    logic            shown;

    always_comb begin
        cell_h  = CY_W'(max_scan) + CY_W'(1);
        top_row = CY_W'(cur_addr_hi) * cell_h + CY_W'(scan_start[SS_W-2:0]);
        shown   = ~scan_start[SS_W-1];
        row_ext = CY_W'(row);
        delta   = row_ext - top_row;
        row_hit = shown && (row_ext >= top_row) && (delta < CY_W'(CUR_SIZE));
        row_idx = delta[RI_W-1:0];
    end

endmodule

// File: rtl/mono_pixel_overlay.sv
// Selects the memory bit, merges the cursor bit and registers the pixel.
module mono_pixel_overlay #(
    parameter int COL_W    = 10,
    parameter int WORD_W   = 32,
    parameter int CUR_SIZE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en,
    input  logic [COL_W-1:0]    pix_col,
    input  logic [WORD_W-1:0]   word,
    input  logic [COL_W-1:0]    cur_x,
    input  logic [CUR_SIZE-1:0] cur_row,
    input  logic                cur_hit,
    input  logic                fn_or,
    input  logic                video_on,
    output logic                pix_vld,
    output logic                pix_out
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int RI_W  = $clog2(CUR_SIZE);

    logic [COL_W:0] dx;
    logic           in_win;
    logic           mem_bit;
    logic           cur_bit;
    logic           mixed;

    always_comb begin
        mem_bit = word[pix_col[BIT_W-1:0]];
        dx      = {1'b0, pix_col} - {1'b0, cur_x};
        // A negative distance sets the top bit; the window ends at the last column.
        in_win  = cur_hit && !dx[COL_W] && (dx < (COL_W+1)'(CUR_SIZE));
        cur_bit = in_win && cur_row[dx[RI_W-1:0]];
        mixed   = fn_or ? (mem_bit | cur_bit) : (mem_bit & ~cur_bit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_vld <= 1'b0;
            pix_out <= 1'b0;
        end else begin
            pix_vld <= pix_en;
            pix_out <= pix_en && video_on && mixed;
        end
    end

endmodule

// File: rtl/mono_fetch_fsm.sv
// Row setup and in-row word streaming against a one-cycle-latency memory.
module mono_fetch_fsm
    import mono_scan_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          WORD_W   = 32,
    parameter int          COL_W    = 10,
    parameter int          ROW_W    = 10,
    parameter int          LINE_W   = 11,
    parameter int          COLS     = 1024,
    parameter int          CUR_SIZE = 16,
    parameter logic [15:0] MAP_BASE = 16'hFE00,
    parameter logic [15:0] CUR_BASE = 16'hFFF8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_go,
    input  logic [ROW_W-1:0]            line_y,
    input  logic                        pix_en,
    input  logic [COL_W-1:0]            pix_col,
    output logic                        mem_req,
    output logic [AW-1:0]               mem_addr,
    input  logic [WORD_W-1:0]           mem_rdata,
    output logic [ROW_W-1:0]            row_q,
    input  logic                        row_hit,
    input  logic [$clog2(CUR_SIZE)-1:0] row_idx,
    output logic [WORD_W-1:0]           word_q,
    output logic [CUR_SIZE-1:0]         crow_q,
    output logic                        chit_q
);
    localparam int WPL    = COLS / WORD_W;
    localparam int WIDX_W = $clog2(WPL);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int HALF   = WORD_W / 2;
    localparam int MAP_LO = 0;
    localparam int MAP_HI = HALF;

    scan_state_e          state, state_nx;
    logic [LINE_W-1:0]    bufln_q;
    logic [WORD_W-1:0]    next_q;
    logic [WIDX_W:0]      widx_q;
    logic                 refill_q;
    logic                 boundary;
    logic                 last_col;

    assign boundary = pix_en && (pix_col[BIT_W-1:0] == {BIT_W{1'b1}});
    assign last_col = pix_en && (pix_col == COL_W'(COLS - 1));

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = ST_IDLE;
            ST_MAP_REQ: state_nx = ST_CUR_REQ;
            ST_CUR_REQ: state_nx = ST_W0_REQ;
            ST_W0_REQ:  state_nx = ST_W1_REQ;
            ST_W1_REQ:  state_nx = ST_W1_WAIT;
            ST_W1_WAIT: state_nx = ST_SCAN;
            ST_SCAN:    state_nx = last_col ? ST_IDLE : ST_SCAN;
            default:    state_nx = ST_IDLE;
        endcase
        if (line_go) state_nx = ST_MAP_REQ;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Memory request outputs.
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        unique case (state)
            ST_IDLE: begin
                mem_req = 1'b0;
            end
            ST_MAP_REQ: begin
                mem_req  = 1'b1;
                mem_addr = AW'(MAP_BASE) + AW'(row_q >> 1);
            end
            ST_CUR_REQ: begin
                mem_req  = 1'b1;
                mem_addr = AW'(CUR_BASE) + AW'(row_idx >> 1);
            end
            ST_W0_REQ: begin
                mem_req  = 1'b1;
                mem_addr = AW'({bufln_q, WIDX_W'(0)});
            end
            ST_W1_REQ: begin
                mem_req  = 1'b1;
                mem_addr = AW'({bufln_q, WIDX_W'(1)});
            end
            ST_W1_WAIT: begin
                mem_req = 1'b0;
            end
            ST_SCAN: begin
                mem_req  = boundary && (widx_q < (WIDX_W+1)'(WPL));
                mem_addr = AW'({bufln_q, widx_q[WIDX_W-1:0]});
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // Data path registers that follow the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            bufln_q  <= '0;
            word_q   <= '0;
            next_q   <= '0;
            crow_q   <= '0;
            chit_q   <= 1'b0;
            widx_q   <= '0;
            refill_q <= 1'b0;
        end else if (line_go) begin
            row_q    <= line_y;
            refill_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_MAP_REQ: begin
                    refill_q <= 1'b0;
                end
                ST_CUR_REQ: begin
                    bufln_q <= row_q[0] ? mem_rdata[MAP_HI +: LINE_W]
                                        : mem_rdata[MAP_LO +: LINE_W];
                end
                ST_W0_REQ: begin
                    crow_q <= row_idx[0] ? mem_rdata[WORD_W-1:HALF]
                                         : mem_rdata[HALF-1:0];
                    chit_q <= row_hit;
                end
                ST_W1_REQ: begin
                    word_q <= mem_rdata;
                end
                ST_W1_WAIT: begin
                    next_q <= mem_rdata;
                    widx_q <= (WIDX_W+1)'(2);
                end
                ST_SCAN: begin
                    if (refill_q) begin
                        next_q <= mem_rdata;
                        widx_q <= widx_q + 1'b1;
                    end
                    if (boundary) begin
                        word_q <= next_q;
                    end
                    refill_q <= boundary && (widx_q < (WIDX_W+1)'(WPL));
                end
                default: begin
                    refill_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mono_scanout.sv
module mono_scanout #(
    parameter int          COLS     = 1024,
    parameter int          ROWS     = 864,
    parameter int          WORD_W   = 32,
    parameter int          AW       = 16,
    parameter int          LINE_W   = 11,
    parameter int          CUR_SIZE = 16,
    parameter int          AH_W     = 8,
    parameter int          MS_W     = 5,
    parameter int          SS_W     = 6,
    parameter logic [15:0] MAP_BASE = 16'hFE00,
    parameter logic [15:0] CUR_BASE = 16'hFFF8,
    localparam int         COL_W    = $clog2(COLS),
    localparam int         ROW_W    = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_go,
    input  logic [ROW_W-1:0]  line_y,
    input  logic              pix_en,
    input  logic [COL_W-1:0]  pix_col,
    input  logic              cur_or,
    input  logic              video_on,
    input  logic [COL_W-1:0]  cursor_x,
    input  logic [AH_W-1:0]   cur_addr_hi,
    input  logic [MS_W-1:0]   max_scan,
    input  logic [SS_W-1:0]   scan_start,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              pix_vld,
    output logic              pix_out
);
    localparam int RI_W = $clog2(CUR_SIZE);

    logic [ROW_W-1:0]    row_q;
    logic                row_hit;
    logic [RI_W-1:0]     row_idx;
    logic [WORD_W-1:0]   word_q;
    logic [CUR_SIZE-1:0] crow_q;
    logic                chit_q;

    mono_cursor_geom #(
        .ROW_W(ROW_W), .AH_W(AH_W), .MS_W(MS_W), .SS_W(SS_W), .CUR_SIZE(CUR_SIZE)
    ) u_geom (
        .row        (row_q),
        .cur_addr_hi(cur_addr_hi),
        .max_scan   (max_scan),
        .scan_start (scan_start),
        .row_hit    (row_hit),
        .row_idx    (row_idx)
    );

    mono_fetch_fsm #(
        .AW(AW), .WORD_W(WORD_W), .COL_W(COL_W), .ROW_W(ROW_W), .LINE_W(LINE_W),
        .COLS(COLS), .CUR_SIZE(CUR_SIZE), .MAP_BASE(MAP_BASE), .CUR_BASE(CUR_BASE)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_go  (line_go),
        .line_y   (line_y),
        .pix_en   (pix_en),
        .pix_col  (pix_col),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .row_q    (row_q),
        .row_hit  (row_hit),
        .row_idx  (row_idx),
        .word_q   (word_q),
        .crow_q   (crow_q),
        .chit_q   (chit_q)
    );

    mono_pixel_overlay #(
        .COL_W(COL_W), .WORD_W(WORD_W), .CUR_SIZE(CUR_SIZE)
    ) u_mix (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_en  (pix_en),
        .pix_col (pix_col),
        .word    (word_q),
        .cur_x   (cursor_x),
        .cur_row (crow_q),
        .cur_hit (chit_q),
        .fn_or   (cur_or),
        .video_on(video_on),
        .pix_vld (pix_vld),
        .pix_out (pix_out)
    );

endmodule

// File: rtl/mono_scanout_chk.sv
module mono_scanout_chk #(
    parameter int          COL_W    = 10,
    parameter int          ROW_W    = 10,
    parameter int          AW       = 16,
    parameter logic [15:0] MAP_BASE = 16'hFE00
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_go,
    input logic [ROW_W-1:0] line_y,
    input logic             pix_en,
    input logic [COL_W-1:0] pix_col,
    input logic             video_on,
    input logic             mem_req,
    input logic [AW-1:0]    mem_addr,
    input logic             pix_vld,
    input logic             pix_out
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: first cycle out of reset is quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> (!pix_vld && !pix_out && !mem_req));

    // R4: one pixel out one cycle after each strobe, none without
    a_r4_vld_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> pix_vld);
    a_r4_no_vld_without_en: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> (!pix_vld && !pix_out));

    // R9: video off forces a dark pixel
    a_r9_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !video_on) |=> !pix_out);

    // R10: in-row reads only at the last column of a word
    a_r10_read_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && pix_en && !line_go) |-> (pix_col[4:0] == 5'd31));

    // R2: map entry read right after the row pulse
    a_r2_map_address: assert property (@(posedge clk) disable iff (!rst_n)
        (line_go && !rst_seen) |=> (mem_req && (mem_addr == AW'(MAP_BASE) + AW'($past(line_y) >> 1))));

endmodule

bind mono_scanout mono_scanout_chk #(
    .COL_W(COL_W), .ROW_W(ROW_W), .AW(AW), .MAP_BASE(MAP_BASE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_go (line_go),
    .line_y  (line_y),
    .pix_en  (pix_en),
    .pix_col (pix_col),
    .video_on(video_on),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .pix_vld (pix_vld),
    .pix_out (pix_out)
);

// File: tb/mono_scanout_tb.sv
module mono_scanout_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COLS       = 1024;
    localparam int MAP_BASE   = 16'hFE00;
    localparam int CUR_BASE   = 16'hFFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_go = 1'b0;
    logic [9:0]  line_y = '0;
    logic        pix_en = 1'b0;
    logic [9:0]  pix_col = '0;
    logic        cur_or = 1'b0;
    logic        video_on = 1'b0;
    logic [9:0]  cursor_x = '0;
    logic [7:0]  cur_addr_hi = '0;
    logic [4:0]  max_scan = '0;
    logic [5:0]  scan_start = 6'h20;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        pix_vld;
    logic        pix_out;

    int vectors = 0;
    int fails   = 0;
    int mapoff  = 0;
    logic [31:0] seed = 32'h5A17_C3E1;
    logic [15:0] cur_img [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    mono_scanout u_dut (
        .clk(clk), .rst_n(rst_n), .line_go(line_go), .line_y(line_y),
        .pix_en(pix_en), .pix_col(pix_col), .cur_or(cur_or), .video_on(video_on),
        .cursor_x(cursor_x), .cur_addr_hi(cur_addr_hi), .max_scan(max_scan),
        .scan_start(scan_start), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pix_vld(pix_vld), .pix_out(pix_out)
    );

    function automatic int map_fn(int s);
        return ((s * 7) + mapoff) & 32'h3FF;
    endfunction

    function automatic logic [31:0] data_fn(int a);
        logic [31:0] av = 32'(a);
        return (av * 32'h9E37_79B1) ^ seed ^ (av << 13);
    endfunction

    function automatic logic [31:0] mem_word(int a);
        int k;
        if (a >= CUR_BASE) begin
            k = a - CUR_BASE;
            return {cur_img[2*k+1], cur_img[2*k]};
        end else if (a >= MAP_BASE) begin
            k = a - MAP_BASE;
            // junk in the bits the map entry must ignore (R2)
            return {5'h1B, 11'(map_fn(2*k+1)), 5'h0E, 11'(map_fn(2*k))};
        end
        return data_fn(a);
    endfunction

    // One-cycle-latency read port
    always @(posedge clk) if (mem_req) mem_rdata <= mem_word(int'(mem_addr));

    function automatic logic exp_pix(int y, int c);
        int b, cy, cx;
        logic m, cb, o;
        b  = map_fn(y);
        m  = data_fn(b * 32 + c / 32)[c % 32];
        cy = int'(cur_addr_hi) * (int'(max_scan) + 1) + int'(scan_start[4:0]);
        cx = int'(cursor_x);
        cb = 1'b0;
        if (!scan_start[5] && y >= cy && y < cy + 16 && c >= cx && c < cx + 16)
            cb = cur_img[y - cy][c - cx];
        o = cur_or ? (m | cb) : (m & ~cb);
        return video_on & o;
    endfunction

    task automatic run_line(input int y, input string tag);
        int bad = 0;
        @(negedge clk);
        line_go = 1'b1; line_y = 10'(y);
        @(negedge clk);
        line_go = 1'b0;
        repeat (6) @(negedge clk);
        for (int c = 0; c < COLS; c++) begin
            logic e;
            pix_en = 1'b1; pix_col = 10'(c);
            @(negedge clk);
            e = exp_pix(y, c);
            vectors++;
            if (pix_vld !== 1'b1 || pix_out !== e) begin
                fails++; bad++;
                if (bad <= 8)
                    $display("FAIL %s row %0d col %0d: vld=%b pix=%b expected vld=1 pix=%b",
                             tag, y, c, pix_vld, pix_out, e);
            end
        end
        pix_en = 1'b0;
        @(negedge clk);
        vectors++;
        if (pix_vld !== 1'b0) begin
            fails++;
            $display("FAIL R4 row %0d: vld after last strobe=%b expected 0", y, pix_vld);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        vectors++;
        if (pix_vld !== 1'b0 || pix_out !== 1'b0 || mem_req !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: vld=%b pix=%b req=%b expected 0 0 0", pix_vld, pix_out, mem_req);
        end
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (pix_vld !== 1'b0 || pix_out !== 1'b0 || mem_req !== 1'b0) begin
            fails++;
            $display("FAIL R1 after release: vld=%b pix=%b req=%b expected 0 0 0", pix_vld, pix_out, mem_req);
        end
    endtask

    task automatic t_plain();
        video_on = 1'b1; cur_or = 1'b1; scan_start = 6'h20;
        mapoff = 0;
        run_line(0, "R2_R3_even");
        run_line(1, "R2_R3_odd");
    endtask

    task automatic t_remap();
        mapoff = 333; seed = 32'h0BAD_F00D;
        run_line(863, "R2_remap_last");
        run_line(500, "R3_remap_mid");
    endtask

    task automatic t_cursor_or();
        cur_addr_hi = 8'd3; max_scan = 5'd9; scan_start = 6'd4;   // top row 34
        cursor_x = 10'd100; cur_or = 1'b1;
        run_line(34, "R5_R7_R8_or_top");
        run_line(41, "R7_or_row7");
        run_line(49, "R7_or_row15");
        run_line(50, "R5_below");
        run_line(33, "R5_above");
    endtask

    task automatic t_cursor_andnot();
        cur_or = 1'b0;
        run_line(40, "R8_andnot");
    endtask

    task automatic t_clip();
        cursor_x = 10'd1020; cur_or = 1'b1;
        run_line(35, "R6_clip");
    endtask

    task automatic t_hidden();
        scan_start = 6'h24;
        run_line(38, "R5_hidden");
    endtask

    task automatic t_video_off();
        scan_start = 6'd4; video_on = 1'b0;
        run_line(36, "R9_video_off");
        video_on = 1'b1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        for (int r = 0; r < 16; r++)
            cur_img[r] = 16'hF00F ^ 16'(r * 16'h1357);
        t_reset();
        t_plain();
        t_remap();
        t_cursor_or();
        t_cursor_andnot();
        t_clip();
        t_hidden();
        t_video_off();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

endmodule